// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Array

This block is a small, fully associative translation cache. Every entry holds a virtual page number, the physical page number it maps to, four permission bits, and the address space identifier that was current when the entry was filled. A lookup hits only when the virtual page number matches and the stored identifier equals the identifier now held in the satp ASID field. This lets mappings from several address spaces share the array without interfering with each other.

Entries arrive through a refill port, which stamps each new entry with the current identifier. A fence request clears the whole array. Its register operands and their validity flags are accepted at the port but do not narrow the flush. When the current identifier changes, the block raises a one-cycle flush pulse so that outstanding page walks can be cancelled. The stored entries are left untouched by that change.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: `lookup_hit` is high only when `lookup_valid` is high and a valid entry matches both `lookup_vpn` and the low ASID_W bits of `satp_asid_field`. On a hit, `lookup_ppn` and `lookup_perm` give that entry's stored values, with permission bit 3 for read, bit 2 for write, bit 1 for execute and bit 0 for user. On a miss, both read zero.
- R3: A refill stores the ASID that is current in its cycle and becomes visible from the next cycle. A lookup of the same page in the refill cycle misses.
- R4: The same virtual page refilled under two different ASIDs is held as two entries. Each ASID receives its own physical page.
- R5: `walk_flush` is high in exactly those cycles where the low ASID_W bits of `satp_asid_field` differ from the value registered at the previous clock edge. An ASID change leaves stored entries valid, so switching back hits again.
- R6: Bits of `satp_asid_field` above ASID_W have no effect on hits or on `walk_flush`.
- R7: `sfence_valid` invalidates every entry from the next cycle, whatever the values of `sfence_rs1_val`, `sfence_rs2_val` and their valid flags. A refill in the same cycle is dropped.
- R8: A refill goes to the slot chosen by this order. First, an existing entry with the same VPN and ASID is overwritten. Otherwise the lowest-numbered invalid slot is used. Otherwise the round-robin slot is used. The round-robin pointer starts at 0 after reset and advances by one, with wraparound, on each round-robin replacement.
- R9: With `lookup_valid` low, `lookup_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| satp_asid_field | input | SATP_ASID_BITS | ASID field of satp; only the low ASID_W bits are used |
| refill_valid | input | 1 | Write a new entry |
| refill_vpn | input | VPN_W | Virtual page number of the new entry |
| refill_ppn | input | PPN_W | Physical page number of the new entry |
| refill_perm | input | 4 | Permissions {r,w,x,u} of the new entry |
| lookup_valid | input | 1 | Lookup request |
| lookup_vpn | input | VPN_W | Page to translate |
| lookup_hit | output | 1 | Translation found |
| lookup_ppn | output | PPN_W | Translated page, zero on miss |
| lookup_perm | output | 4 | Permissions of the hit entry, zero on miss |
| sfence_valid | input | 1 | Flush all entries |
| sfence_rs1_valid | input | 1 | Address operand present (ignored) |
| sfence_rs2_valid | input | 1 | ASID operand present (ignored) |
| sfence_rs1_val | input | VPN_W | Address operand value (ignored) |
| sfence_rs2_val | input | SATP_ASID_BITS | ASID operand register contents (ignored) |
| walk_flush | output | 1 | Cancel in-flight page walks |

## Verification
The bench builds the block with ENTRIES=4, ASID_W=8 and SATP_ASID_BITS=16. With only four slots, a handful of refills fills the array, which brings the round-robin eviction and pointer wraparound within reach. The eight unused upper bits of the 16-bit satp field give room to show that changing them neither raises the walk flush nor changes hits. With an 8-bit identifier, two address spaces can map the same page to different frames and be switched back and forth.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
        logic u;
    } perm_t;

    localparam int PERM_W = $bits(perm_t);

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int N      = 8,
    parameter int VPN_W  = 27,
    parameter int ASID_W = 16
) (
    input  logic [N-1:0]             vld,
    input  logic [N-1:0][VPN_W-1:0]  tag_vpn,
    input  logic [N-1:0][ASID_W-1:0] tag_asid,
    input  logic [VPN_W-1:0]         key_vpn,
    input  logic [ASID_W-1:0]        key_asid,
    output logic [N-1:0]             match
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = vld[i] && (tag_vpn[i] == key_vpn) && (tag_asid[i] == key_asid);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vld,
    input  logic [N-1:0]     dup,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] slot,
    output logic             use_rr
);
    logic             dup_found;
    logic [IDX_W-1:0] dup_idx;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        dup_found  = 1'b0;
        dup_idx    = '0;
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (dup[i]) begin
                dup_found = 1'b1;
                dup_idx   = IDX_W'(i);
            end
            if (!vld[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        use_rr = 1'b0;
        if (dup_found)       slot = dup_idx;
        else if (free_found) slot = free_idx;
        else begin
            slot   = rr_ptr;
            use_rr = 1'b1;
        end
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES        = 8,
    parameter int VPN_W          = 27,
    parameter int PPN_W          = 24,
    parameter int ASID_W         = 8,
    parameter int SATP_ASID_BITS = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SATP_ASID_BITS-1:0] satp_asid_field,
    input  logic                      refill_valid,
    input  logic [VPN_W-1:0]          refill_vpn,
    input  logic [PPN_W-1:0]          refill_ppn,
    input  logic [PERM_W-1:0]         refill_perm,
    input  logic                      lookup_valid,
    input  logic [VPN_W-1:0]          lookup_vpn,
    output logic                      lookup_hit,
    output logic [PPN_W-1:0]          lookup_ppn,
    output logic [PERM_W-1:0]         lookup_perm,
    input  logic                      sfence_valid,
    input  logic                      sfence_rs1_valid,
    input  logic                      sfence_rs2_valid,
    input  logic [VPN_W-1:0]          sfence_rs1_val,
    input  logic [SATP_ASID_BITS-1:0] sfence_rs2_val,
    output logic                      walk_flush
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][ASID_W-1:0] asid;
        logic [ENTRIES-1:0][PPN_W-1:0]  ppn;
        perm_t [ENTRIES-1:0]            perm;
        logic [IDX_W-1:0]               rr;
        logic [ASID_W-1:0]              cur;
    } state_t;

    state_t st_d, st_q;

    logic [ASID_W-1:0]  cur_asid;
    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] dup_vec;
    logic [IDX_W-1:0]   slot;
    logic               use_rr;

    assign cur_asid = satp_asid_field[ASID_W-1:0];

    logic unused_sfence_args;
    assign unused_sfence_args = ^{sfence_rs1_valid, sfence_rs2_valid, sfence_rs1_val,
                                  sfence_rs2_val, satp_asid_field};

    tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lookup_cam (
        .vld(st_q.vld), .tag_vpn(st_q.vpn), .tag_asid(st_q.asid),
        .key_vpn(lookup_vpn), .key_asid(cur_asid), .match(hit_vec)
    );

    tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_refill_cam (
        .vld(st_q.vld), .tag_vpn(st_q.vpn), .tag_asid(st_q.asid),
        .key_vpn(refill_vpn), .key_asid(cur_asid), .match(dup_vec)
    );

    tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .vld(st_q.vld), .dup(dup_vec), .rr_ptr(st_q.rr), .slot(slot), .use_rr(use_rr)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cur = cur_asid;
        if (sfence_valid) begin
            st_d.vld = '0;
        end else if (refill_valid) begin
            st_d.vld[slot]  = 1'b1;
            st_d.vpn[slot]  = refill_vpn;
            st_d.asid[slot] = cur_asid;
            st_d.ppn[slot]  = refill_ppn;
            st_d.perm[slot] = perm_t'(refill_perm);
            if (use_rr) begin
                st_d.rr = (st_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_comb begin
        lookup_hit  = lookup_valid && (|hit_vec);
        lookup_ppn  = '0;
        lookup_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lookup_valid && hit_vec[i]) begin
                lookup_ppn  = lookup_ppn | st_q.ppn[i];
                lookup_perm = lookup_perm | st_q.perm[i];
            end
        end
    end

    assign walk_flush = (cur_asid != st_q.cur);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R9
    hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_hit |-> lookup_valid);

    // R3
    refill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(refill_valid && !sfence_valid) && lookup_valid
         && lookup_vpn == $past(refill_vpn) && $stable(cur_asid)) |-> lookup_hit);

    // R7
    sfence_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sfence_valid |=> !lookup_hit);

    // R5
    flush_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(cur_asid)) |-> !walk_flush);

    // R5
    entries_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sfence_valid |=> $countones(st_q.vld) >= $past($countones(st_q.vld)));
endmodule

// File: tb/tb_asid_tlb.sv
`timescale 1ns/1ps
module tb_asid_tlb;
    localparam int ENTRIES = 4;
    localparam int VPN_W   = 20;
    localparam int PPN_W   = 20;
    localparam int ASID_W  = 8;
    localparam int SB      = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [SB-1:0]    satp_asid_field = '0;
    logic             refill_valid = 1'b0;
    logic [VPN_W-1:0] refill_vpn = '0;
    logic [PPN_W-1:0] refill_ppn = '0;
    logic [3:0]       refill_perm = '0;
    logic             lookup_valid = 1'b0;
    logic [VPN_W-1:0] lookup_vpn = '0;
    logic             lookup_hit;
    logic [PPN_W-1:0] lookup_ppn;
    logic [3:0]       lookup_perm;
    logic             sfence_valid = 1'b0;
    logic             sfence_rs1_valid = 1'b0;
    logic             sfence_rs2_valid = 1'b0;
    logic [VPN_W-1:0] sfence_rs1_val = '0;
    logic [SB-1:0]    sfence_rs2_val = '0;
    logic             walk_flush;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    asid_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W),
               .SATP_ASID_BITS(SB)) dut (
        .clk(clk), .rst_n(rst_n), .satp_asid_field(satp_asid_field),
        .refill_valid(refill_valid), .refill_vpn(refill_vpn), .refill_ppn(refill_ppn),
        .refill_perm(refill_perm), .lookup_valid(lookup_valid), .lookup_vpn(lookup_vpn),
        .lookup_hit(lookup_hit), .lookup_ppn(lookup_ppn), .lookup_perm(lookup_perm),
        .sfence_valid(sfence_valid), .sfence_rs1_valid(sfence_rs1_valid),
        .sfence_rs2_valid(sfence_rs2_valid), .sfence_rs1_val(sfence_rs1_val),
        .sfence_rs2_val(sfence_rs2_val), .walk_flush(walk_flush)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic refill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                          input logic [3:0] pm);
        @(negedge clk);
        refill_valid = 1'b1; refill_vpn = v; refill_ppn = p; refill_perm = pm;
        @(negedge clk);
        refill_valid = 1'b0;
    endtask

    task automatic look(input string req, input logic [VPN_W-1:0] v, input bit exp_hit,
                        input logic [PPN_W-1:0] exp_ppn, input logic [3:0] exp_perm);
        @(negedge clk);
        lookup_valid = 1'b1; lookup_vpn = v;
        #1;
        check(req, 32'(lookup_hit), 32'(exp_hit));
        check(req, 32'(lookup_ppn), exp_hit ? 32'(exp_ppn) : 32'h0);
        if (exp_hit) check(req, 32'(lookup_perm), 32'(exp_perm));
        lookup_valid = 1'b0;
    endtask

    task automatic set_asid(input logic [SB-1:0] a);
        @(negedge clk);
        satp_asid_field = a;
    endtask

    task automatic do_sfence();
        @(negedge clk);
        sfence_valid = 1'b1; sfence_rs1_valid = 1'b1; sfence_rs2_valid = 1'b1;
        sfence_rs1_val = 20'h00010; sfence_rs2_val = 16'h0005;
        @(negedge clk);
        sfence_valid = 1'b0; sfence_rs1_valid = 1'b0; sfence_rs2_valid = 1'b0;
    endtask

    task automatic t_reset();
        look("R1", 20'h00000, 1'b0, '0, '0);
        look("R1", 20'h00abc, 1'b0, '0, '0);
        check("R5", 32'(walk_flush), 32'h0);
    endtask

    task automatic t_basic();
        set_asid(16'h0001);
        @(negedge clk);
        refill(20'h00abc, 20'h11111, 4'b1010);
        look("R2", 20'h00abc, 1'b1, 20'h11111, 4'b1010);
        look("R2", 20'h00abd, 1'b0, '0, '0);
        @(negedge clk);
        lookup_valid = 1'b0; lookup_vpn = 20'h00abc;
        #1 check("R9", 32'(lookup_hit), 32'h0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        refill_valid = 1'b1; refill_vpn = 20'h00bbb; refill_ppn = 20'h22222; refill_perm = 4'b1100;
        lookup_valid = 1'b1; lookup_vpn = 20'h00bbb;
        #1 check("R3", 32'(lookup_hit), 32'h0);
        @(negedge clk);
        refill_valid = 1'b0;
        #1 check("R3", 32'(lookup_hit), 32'h1);
        check("R3", 32'(lookup_ppn), 32'h22222);
        lookup_valid = 1'b0;
    endtask

    task automatic t_asid_switch();
        set_asid(16'h0002);
        #1 check("R5", 32'(walk_flush), 32'h1);
        @(negedge clk);
        #1 check("R5", 32'(walk_flush), 32'h0);
        look("R2", 20'h00abc, 1'b0, '0, '0);
        refill(20'h00abc, 20'h33333, 4'b0110);
        look("R4", 20'h00abc, 1'b1, 20'h33333, 4'b0110);
        set_asid(16'h0001);
        #1 check("R5", 32'(walk_flush), 32'h1);
        look("R4", 20'h00abc, 1'b1, 20'h11111, 4'b1010);
        look("R5", 20'h00bbb, 1'b1, 20'h22222, 4'b1100);
    endtask

    task automatic t_upper_bits();
        set_asid(16'h7f01);
        #1 check("R6", 32'(walk_flush), 32'h0);
        look("R6", 20'h00abc, 1'b1, 20'h11111, 4'b1010);
        set_asid(16'h0001);
        #1 check("R6", 32'(walk_flush), 32'h0);
    endtask

    task automatic t_sfence();
        do_sfence();
        look("R7", 20'h00abc, 1'b0, '0, '0);
        look("R7", 20'h00bbb, 1'b0, '0, '0);
        set_asid(16'h0002);
        look("R7", 20'h00abc, 1'b0, '0, '0);
        set_asid(16'h0001);
        @(negedge clk);
        sfence_valid = 1'b1; refill_valid = 1'b1;
        refill_vpn = 20'h00ccc; refill_ppn = 20'h44444; refill_perm = 4'b1000;
        @(negedge clk);
        sfence_valid = 1'b0; refill_valid = 1'b0;
        look("R7", 20'h00ccc, 1'b0, '0, '0);
    endtask

    task automatic t_replace();
        for (int i = 0; i < 4; i++) refill(20'(16 + i), 20'(32'h100 + i), 4'b1111);
        for (int i = 0; i < 4; i++) look("R8", 20'(16 + i), 1'b1, 20'(32'h100 + i), 4'b1111);
        refill(20'd20, 20'h00200, 4'b0001);
        look("R8", 20'd16, 1'b0, '0, '0);
        look("R8", 20'd17, 1'b1, 20'h00101, 4'b1111);
        look("R8", 20'd20, 1'b1, 20'h00200, 4'b0001);
        refill(20'd21, 20'h00201, 4'b0001);
        look("R8", 20'd17, 1'b0, '0, '0);
        refill(20'd18, 20'h00300, 4'b0100);
        look("R8", 20'd18, 1'b1, 20'h00300, 4'b0100);
        look("R8", 20'd19, 1'b1, 20'h00103, 4'b1111);
        look("R8", 20'd21, 1'b1, 20'h00201, 4'b0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_same_cycle();
        t_asid_switch();
        t_upper_bits();
        t_sfence();
        t_replace();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule